// File: doc/BRIEF.md
# Programmable I2C Clock-Line Timing Generator

This block produces the clock-line waveform for an I2C controller from a fixed source clock. A shared prescaler divides the source clock into a base tick. Three programmable counts, all in base ticks, set how long the clock line is held low, how long it is released high, and the length of the whole bit period. If the period count is larger than the high and low counts together, the extra ticks go to the low phase. The generator releases the line at the end of the low phase. It does not count the high phase until the sensed line actually reads high, so a target that holds the line low stretches the clock.

Besides the line drive, the block gives the byte sequencer two single-cycle strobes. One marks the middle of the low phase, where the data line may change. The other marks the middle of the high phase, where the data line should be sampled. START, STOP and byte framing are decided outside this block. The prescaler value and the packed count word are captured when the generator is enabled and are held until it is disabled again.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, `scl_oe_o`, `chg_stb_o` and `smp_stb_o` are all 0.
- R2: One cycle after `en_i` is sampled low, `scl_oe_o` and both strobes are 0, and they stay 0 while `en_i` stays low.
- R3: `cfg_i` carries the high count in bits 29:20, the low count in bits 19:10 and the period count in bits 9:0. A prescaler value of 0 acts as 1, and a high or low count of 0 acts as 1.
- R4: One cycle after `en_i` is first sampled high, `scl_oe_o` rises (the line is pulled low). Each low phase lasts LX×D source cycles, where D is the effective prescaler value and LX is the effective low count as defined in R5.
- R5: If the period count C is greater than H+L (the effective high and low counts), then LX = C−H. Otherwise LX = L.
- R6: With no stretching, each released (high) phase lasts H×D cycles, after which `scl_oe_o` rises again.
- R7: While the line is released but sensed low on `scl_in_i`, the high count does not advance. Every such cycle lengthens the high phase by one cycle.
- R8: `chg_stb_o` pulses exactly once per low phase, floor(LX/2)×D+1 cycles after `scl_oe_o` rises.
- R9: `smp_stb_o` pulses once per high phase, S+floor(H/2)×D+1 cycles after `scl_oe_o` falls, where S is the number of stretched cycles at the start of the phase.
- R10: Changes on `div_i` or `cfg_i` while the generator is enabled have no effect on the timing until it is disabled and enabled again.
- R11: `chg_stb_o` and `smp_stb_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run the generator; low returns it to idle with the line released |
| div_i | input | 8 | Prescaler value in source clocks per base tick |
| cfg_i | input | 30 | Packed high, low and period counts |
| scl_in_i | input | 1 | Sensed clock line level, already synchronised |
| scl_oe_o | output | 1 | 1 pulls the clock line low |
| chg_stb_o | output | 1 | Data-change strobe at the middle of the low phase |
| smp_stb_o | output | 1 | Data-sample strobe at the middle of the high phase |

## Verification
If the phase counter or prescaler holds a wrong value, the distance between the edges of `scl_oe_o` changes within a single bit period, so measuring one low and one high phase per configuration exposes it. If the stretch gating is wrong, the high phase comes out shorter than S+H×D, and `smp_stb_o` moves earlier, within the first stretched bit. A shadow register that reloads while enabled shows up as a changed period in the same bit, because the bench scrambles the inputs right after start.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

endpackage

// File: rtl/scl_tick_div.sv
// Prescaler: one base tick every D source cycles while running.
module scl_tick_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic             at_zero_o
);

  logic [DIV_W-1:0] pc_q;
  logic             last;

  assign last      = (pc_q == div_i - DIV_W'(1));
  assign tick_o    = run_i && last;
  assign at_zero_o = (pc_q == '0);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      pc_q <= '0;
    end else if (run_i) begin
      pc_q <= last ? '0 : pc_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/scl_cfg_shadow.sv
// Captures divider and counts at start; derives effective values.
module scl_cfg_shadow #(
  parameter int DIV_W = 8,
  parameter int CNT_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [3*CNT_W-1:0] cfg_i,
  output logic [DIV_W-1:0]   div_o,
  output logic [CNT_W-1:0]   high_o,
  output logic [CNT_W-1:0]   low_o
);

  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] raw_hi, raw_lo, raw_per;
  logic [CNT_W-1:0] hi_eff, lo_eff, lo_pad;
  logic [DIV_W-1:0] div_eff;
  logic [SUM_W-1:0] used;

  assign raw_hi  = cfg_i[3*CNT_W-1:2*CNT_W];
  assign raw_lo  = cfg_i[2*CNT_W-1:CNT_W];
  assign raw_per = cfg_i[CNT_W-1:0];

  assign div_eff = (div_i  == '0) ? DIV_W'(1) : div_i;
  assign hi_eff  = (raw_hi == '0) ? CNT_W'(1) : raw_hi;
  assign lo_eff  = (raw_lo == '0) ? CNT_W'(1) : raw_lo;
  assign used    = SUM_W'(hi_eff) + SUM_W'(lo_eff);

  // Unused part of the period is added to the low phase.
  always_comb begin
    if (SUM_W'(raw_per) > used) lo_pad = raw_per - hi_eff;
    else                        lo_pad = lo_eff;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_o  <= DIV_W'(1);
      high_o <= CNT_W'(1);
      low_o  <= CNT_W'(1);
    end else if (load_i) begin
      div_o  <= div_eff;
      high_o <= hi_eff;
      low_o  <= lo_pad;
    end
  end

endmodule

// File: rtl/scl_phase_fsm.sv
// Phase sequencing, stretch gating and mid-phase strobes.
module scl_phase_fsm
  import scl_timing_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             at_zero_i,
  input  logic             scl_in_i,
  input  logic [CNT_W-1:0] high_i,
  input  logic [CNT_W-1:0] low_i,
  output scl_phase_e       phase_o,
  output logic             run_o,
  output logic             chg_o,
  output logic             smp_o
);

  scl_phase_e       ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             lo_end, hi_end, chg_d, smp_d;

  assign phase_o = ph_q;
  // High phase counts only while the line reads high.
  assign run_o   = (ph_q == PH_LOW) || ((ph_q == PH_HIGH) && scl_in_i);
  assign lo_end  = (cnt_q == low_i  - CNT_W'(1));
  assign hi_end  = (cnt_q == high_i - CNT_W'(1));
  assign chg_d   = (ph_q == PH_LOW)  && at_zero_i && (cnt_q == (low_i  >> 1));
  assign smp_d   = (ph_q == PH_HIGH) && scl_in_i && at_zero_i &&
                   (cnt_q == (high_i >> 1));

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      chg_o <= 1'b0;
      smp_o <= 1'b0;
    end else begin
      chg_o <= chg_d;
      smp_o <= smp_d;
      case (ph_q)
        PH_IDLE: begin
          ph_q  <= PH_LOW;
          cnt_q <= '0;
        end
        PH_LOW: if (tick_i) begin
          if (lo_end) begin
            ph_q  <= PH_HIGH;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_HIGH: if (tick_i) begin
          if (hi_end) begin
            ph_q  <= PH_LOW;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: begin
          ph_q  <= PH_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [3*CNT_W-1:0] cfg_i,
  input  logic               scl_in_i,
  output logic               scl_oe_o,
  output logic               chg_stb_o,
  output logic               smp_stb_o
);

  scl_phase_e       phase_q;
  logic [DIV_W-1:0] sh_div;
  logic [CNT_W-1:0] sh_high, sh_low;
  logic             run, tick, at_zero, load;

  assign load = en_i && (phase_q == PH_IDLE);

  scl_cfg_shadow #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_shadow (
    .clk(clk), .rst(rst), .load_i(load), .div_i(div_i), .cfg_i(cfg_i),
    .div_o(sh_div), .high_o(sh_high), .low_o(sh_low)
  );

  scl_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .clr_i(phase_q == PH_IDLE), .run_i(run),
    .div_i(sh_div), .tick_o(tick), .at_zero_o(at_zero)
  );

  scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .en_i(en_i), .tick_i(tick), .at_zero_i(at_zero),
    .scl_in_i(scl_in_i), .high_i(sh_high), .low_i(sh_low),
    .phase_o(phase_q), .run_o(run), .chg_o(chg_stb_o), .smp_o(smp_stb_o)
  );

  assign scl_oe_o = (phase_q == PH_LOW);

endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk
  import scl_timing_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             en_i,
  input logic             scl_in_i,
  input logic             scl_oe_o,
  input logic             chg_stb_o,
  input logic             smp_stb_o,
  input scl_phase_e       phase_i,
  input logic [DIV_W-1:0] sh_div_i,
  input logic [CNT_W-1:0] sh_high_i,
  input logic [CNT_W-1:0] sh_low_i
);

  p_release_when_off_r2: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!scl_oe_o && !chg_stb_o && !smp_stb_o));

  p_start_low_r4: assert property (@(posedge clk) disable iff (rst)
    (en_i && phase_i == PH_IDLE) |=> scl_oe_o);

  p_stretch_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (en_i && phase_i == PH_HIGH && !scl_in_i) |=> !scl_oe_o);

  p_chg_after_low_r8: assert property (@(posedge clk) disable iff (rst)
    chg_stb_o |-> $past(scl_oe_o));

  p_smp_after_high_r9: assert property (@(posedge clk) disable iff (rst)
    smp_stb_o |-> $past(!scl_oe_o && scl_in_i));

  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    (en_i && phase_i != PH_IDLE) |=> $stable({sh_div_i, sh_high_i, sh_low_i}));

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(chg_stb_o && smp_stb_o));

endmodule

bind scl_timing_gen scl_timing_gen_chk #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .en_i(en_i), .scl_in_i(scl_in_i),
  .scl_oe_o(scl_oe_o), .chg_stb_o(chg_stb_o), .smp_stb_o(smp_stb_o),
  .phase_i(phase_q), .sh_div_i(sh_div), .sh_high_i(sh_high), .sh_low_i(sh_low)
);

// File: tb/scl_timing_gen_tb_top.sv
`timescale 1ns/1ps
module scl_timing_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_i = 1'b0;
  logic [7:0]  div_i = '0;
  logic [29:0] cfg_i = '0;
  logic        scl_in_i;
  logic        scl_oe_o, chg_stb_o, smp_stb_o;

  int n_chk = 0;
  int n_bad = 0;
  int stretch_cfg = 0;
  int stretch_left = 0;

  always #4 clk = ~clk;

  // Line model: released line reads high after stretch_cfg cycles.
  assign scl_in_i = !scl_oe_o && (stretch_left == 0);
  always @(posedge clk) begin
    if (scl_oe_o) stretch_left <= stretch_cfg;
    else if (stretch_left > 0) stretch_left <= stretch_left - 1;
  end

  scl_timing_gen dut_i (
    .clk(clk), .rst(rst), .en_i(en_i), .div_i(div_i), .cfg_i(cfg_i),
    .scl_in_i(scl_in_i), .scl_oe_o(scl_oe_o), .chg_stb_o(chg_stb_o),
    .smp_stb_o(smp_stb_o)
  );

  function automatic int eff1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int exp_low(input int h, input int l, input int c);
    int he = eff1(h);
    int le = eff1(l);
    return (c > he + le) ? c - he : le;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic run_vec(input int dv, input int h, input int l, input int c,
                         input int s);
    int d  = eff1(dv);
    int lx = exp_low(h, l, c);
    int he = eff1(h);
    int cyc = 0, r = -1, f = -1, r2 = -1, chg_t = -1, smp_t = -1, nchg = 0;
    bit both = 1'b0;
    @(negedge clk);
    div_i = 8'(dv);
    cfg_i = {10'(h), 10'(l), 10'(c)};
    stretch_cfg = s;
    en_i = 1'b1;
    while ((r2 < 0 || smp_t < 0) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 2) begin
        div_i = 8'($urandom_range(255, 0));
        cfg_i = 30'($urandom);
      end
      if (chg_stb_o && smp_stb_o) both = 1'b1;
      if (r < 0 && scl_oe_o) r = cyc;
      else if (r >= 0 && f < 0 && !scl_oe_o) f = cyc;
      else if (f >= 0 && r2 < 0 && scl_oe_o) r2 = cyc;
      if (r >= 0 && r2 < 0 && chg_stb_o) begin
        nchg++;
        if (chg_t < 0) chg_t = cyc;
      end
      if (f >= 0 && smp_t < 0 && smp_stb_o) smp_t = cyc;
    end
    chk(cyc < 20000, "R4 run completes", cyc, 20000);
    chk(r == 1, "R4 line pulled low one cycle after enable", r, 1);
    chk(f - r == lx * d, "R3 R4 R5 low phase length", f - r, lx * d);
    chk(r2 - f == s + he * d, "R6 R7 high phase length", r2 - f, s + he * d);
    chk(r2 - r == (lx + he) * d + s, "R10 period ignores inputs changed while enabled",
        r2 - r, (lx + he) * d + s);
    chk(chg_t - r == (lx >> 1) * d + 1, "R8 change strobe position", chg_t - r,
        (lx >> 1) * d + 1);
    chk(nchg == 1, "R8 one change strobe per low phase", nchg, 1);
    chk(smp_t - f == s + (he >> 1) * d + 1, "R9 sample strobe position", smp_t - f,
        s + (he >> 1) * d + 1);
    chk(!both, "R11 strobes exclusive", int'(both), 0);
    @(negedge clk);
    en_i = 1'b0;
    @(negedge clk);
    chk(!scl_oe_o && !chg_stb_o && !smp_stb_o, "R2 idle after disable",
        int'({scl_oe_o, chg_stb_o, smp_stb_o}), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!scl_oe_o && !chg_stb_o && !smp_stb_o, "R2 stays idle",
          int'({scl_oe_o, chg_stb_o, smp_stb_o}), 0);
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 180000, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5CA1_0B17));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!scl_oe_o && !chg_stb_o && !smp_stb_o, "R1 reset state",
        int'({scl_oe_o, chg_stb_o, smp_stb_o}), 0);
    // Directed: preset rates, zero fields, wide high field, padding with stretch.
    run_vec(7, 10, 11, 26, 0);
    run_vec(2, 5, 12, 24, 0);
    run_vec(1, 3, 9, 18, 0);
    run_vec(0, 0, 0, 0, 0);
    run_vec(1, 1023, 1, 0, 0);
    run_vec(3, 2, 2, 30, 4);
    run_vec(1, 1, 1, 1, 2);
    run_vec(4, 6, 20, 10, 1);
    // Random vectors.
    for (int k = 0; k < 24; k++) begin
      run_vec($urandom_range(7, 0), $urandom_range(40, 0), $urandom_range(40, 0),
              $urandom_range(90, 0), $urandom_range(5, 0));
    end
    finish_run();
  end

endmodule